// File: doc/BRIEF.md
# Virtually Indexed Cache Tag and Dual-Mode Valid Store

This block holds the tags and valid state of an external direct-mapped cache that is indexed and tagged with virtual addresses. One line may hold instructions or data from either privilege mode. Each line carries two valid bits, one for user mode and one for supervisor mode, so the lines of one mode can be discarded without touching the other.

The lookup is purely combinational. This lets the hit decision form in the same cycle as the address translation that runs beside it, instead of waiting for it. A fill port writes a tag and marks the line valid for the requesting mode. The fill is refused when the translation marks the page cache-inhibited. Flushes come from register side effects. A write strobe on either segment table pointer register drops every line of that mode. Any change of the cache-enable bit in the command/status register drops every line of both modes. The command/status register sits inside the block, and it also collects the sticky fault flags.

A two-state controller tracks whether the cache is on. In `ST_OFF` the cache is disabled. In `ST_ON` the cache is enabled. Transition `T_ENABLE` (from `ST_OFF` to `ST_ON`) fires when the enable bit reads 1 while in `ST_OFF`. Transition `T_DISABLE` (from `ST_ON` to `ST_OFF`) fires when the enable bit reads 0 while in `ST_ON`. Each transition asserts a full flush in its cycle.

Top module: `vcache_tag`

## Requirements
- R1: After reset the command/status register reads 0 and every lookup misses.
- R2: After an accepted fill of line address L for mode M, a lookup of L in mode M hits. The hit appears combinationally in the same cycle the lookup address is presented.
- R3: The cache is direct-mapped. The index is line-address bits [IDX_W-1:0], which means VA bits [13:4] for 16 KB with 16-byte lines. The tag is all VA bits above the index. A fill evicts the earlier tag at its index, and a lookup with a different tag at a valid index misses.
- R4: A fill sets the valid bit of the requesting mode and clears the valid bit of the other mode on that line.
- R5: A write strobe on the user segment table pointer clears every user-valid bit and leaves supervisor-valid bits unchanged. From the next cycle, no user-mode lookup hits.
- R6: A write strobe on the supervisor segment table pointer clears every supervisor-valid bit and leaves user-valid bits unchanged. From the next cycle, no supervisor-mode lookup hits.
- R7: Cache enable is bit 2 of the command/status register. While it reads 0, every lookup misses and fills are refused. Any change of that bit, in either direction, flushes both modes on every line before the next cycle. A register write that leaves bit 2 unchanged flushes nothing.
- R8: A fill with the cache-inhibit attribute set changes nothing: the line keeps its earlier tag and valid bits.
- R9: A mode flush and a fill in the same cycle leave that mode's valid bit clear.
- R10: Command/status bits 15, 14 and 13 are the page-table, page and protection fault flags. Bit 3 is the bus-error flag, and it is set with any of them. These flags set from hardware inputs and stay set until a software write. A software write loads bits 15, 14, 13, 6, 5, 3, 2, 1 and 0 from the written data. All other bits read 0. A hardware set wins over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Software write strobe for the command/status register |
| csr_wdata | input | 16 | Software write data |
| csr_rdata | output | 16 | Command/status register contents |
| fault_ptab | input | 1 | Hardware page-table fault event |
| fault_page | input | 1 | Hardware page fault event |
| fault_prot | input | 1 | Hardware protection fault event |
| usp_wr | input | 1 | User segment table pointer was written |
| ssp_wr | input | 1 | Supervisor segment table pointer was written |
| lk_va | input | 28 | Lookup virtual line address (VA bits 31:4) |
| lk_super | input | 1 | Lookup is in supervisor mode |
| lk_hit | output | 1 | Combinational lookup hit |
| fill_req | input | 1 | Fill request |
| fill_va | input | 28 | Fill virtual line address (VA bits 31:4) |
| fill_super | input | 1 | Fill is for supervisor mode |
| fill_inhibit | input | 1 | Translation marks the page cache-inhibited |

## Verification
The checker watches invariants on every cycle:
- no hit unless the controller is on and the enable bit reads 1;
- no hit in the cycle after an enable-bit change;
- no hit in a mode in the cycle after that mode's pointer strobe;
- fault flags that set on their inputs and hold until a software write.

Other behaviours depend on what was filled before, so only the bench scenarios can show them:
- which tag wins at a shared index;
- that a fill clears the other mode's bit;
- that an inhibited fill leaves the old line intact;
- that a mode flush spares the other mode;
- that a same-value enable write keeps the contents.

// File: rtl/vcache_tag_pkg.sv
package vcache_tag_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } cstate_t;

    localparam int CSR_W  = 16;
    localparam int B_PTF  = 15;
    localparam int B_PGF  = 14;
    localparam int B_PRF  = 13;
    localparam int B_FPU  = 6;
    localparam int B_ICE  = 5;
    localparam int B_BERR = 3;
    localparam int B_CEN  = 2;
    localparam int B_SMAP = 1;
    localparam int B_UMAP = 0;

    localparam logic [CSR_W-1:0] CSR_IMPL =
        (16'(1) << B_PTF) | (16'(1) << B_PGF) | (16'(1) << B_PRF) |
        (16'(1) << B_FPU) | (16'(1) << B_ICE) | (16'(1) << B_BERR) |
        (16'(1) << B_CEN) | (16'(1) << B_SMAP) | (16'(1) << B_UMAP);

endpackage

// File: rtl/vcache_tag_csr.sv
module vcache_tag_csr
    import vcache_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [CSR_W-1:0] sw_wdata,
    input  logic             hw_ptab,
    input  logic             hw_page,
    input  logic             hw_prot,
    output logic [CSR_W-1:0] q,
    output logic             en_bit
);

    logic [CSR_W-1:0] nxt;

    always_comb begin
        nxt = sw_wr ? (sw_wdata & CSR_IMPL) : q;
        if (hw_ptab) nxt[B_PTF] = 1'b1;
        if (hw_page) nxt[B_PGF] = 1'b1;
        if (hw_prot) nxt[B_PRF] = 1'b1;
        if (hw_ptab || hw_page || hw_prot) nxt[B_BERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign en_bit = q[B_CEN];

endmodule

// File: rtl/vcache_tag_valid.sv
module vcache_tag_valid #(
    parameter int LINES = 1024,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             flush_u,
    input  logic             flush_s,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_super,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vu,
    output logic             rd_vs
);

    logic [LINES-1:0] vu;
    logic [LINES-1:0] vs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vu <= '0;
            vs <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (flush_all || flush_u)
                    vu[i] <= 1'b0;
                else if (fill_we && fill_idx == IDX_W'(i))
                    vu[i] <= !fill_super;
                if (flush_all || flush_s)
                    vs[i] <= 1'b0;
                else if (fill_we && fill_idx == IDX_W'(i))
                    vs[i] <= fill_super;
            end
        end
    end

    assign rd_vu = vu[rd_idx];
    assign rd_vs = vs[rd_idx];

endmodule

// File: rtl/vcache_tag_store.sv
module vcache_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [TAG_W-1:0] wtag,
    input  logic [IDX_W-1:0] ridx,
    output logic [TAG_W-1:0] rtag
);

    logic [TAG_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wtag;
    end

    assign rtag = mem[ridx];

endmodule

// File: rtl/vcache_tag.sv
module vcache_tag
    import vcache_tag_pkg::*;
#(
    parameter int CACHE_KB   = 16,
    parameter int LINE_BYTES = 16,
    parameter int VA_W       = 32,
    localparam int OFS_W = $clog2(LINE_BYTES),
    localparam int LINES = CACHE_KB * 1024 / LINE_BYTES,
    localparam int IDX_W = $clog2(LINES),
    localparam int LA_W  = VA_W - OFS_W,
    localparam int TAG_W = LA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             fault_ptab,
    input  logic             fault_page,
    input  logic             fault_prot,
    input  logic             usp_wr,
    input  logic             ssp_wr,
    input  logic [LA_W-1:0]  lk_va,
    input  logic             lk_super,
    output logic             lk_hit,
    input  logic             fill_req,
    input  logic [LA_W-1:0]  fill_va,
    input  logic             fill_super,
    input  logic             fill_inhibit
);

    cstate_t          state, state_nxt;
    logic             en_bit;
    logic             flush_all;
    logic             cache_on;
    logic             fill_we;
    logic             rd_vu, rd_vs;
    logic [TAG_W-1:0] rd_tag;

    vcache_tag_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (csr_wr),
        .sw_wdata (csr_wdata),
        .hw_ptab  (fault_ptab),
        .hw_page  (fault_page),
        .hw_prot  (fault_prot),
        .q        (csr_rdata),
        .en_bit   (en_bit)
    );

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // Controller: next state (T_ENABLE / T_DISABLE)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: if (en_bit)  state_nxt = ST_ON;
            ST_ON:  if (!en_bit) state_nxt = ST_OFF;
        endcase
    end

    // Controller: outputs
    always_comb begin
        flush_all = 1'b0;
        cache_on  = 1'b0;
        unique case (state)
            ST_OFF: flush_all = en_bit;
            ST_ON: begin
                flush_all = !en_bit;
                cache_on  = en_bit;
            end
        endcase
    end

    assign fill_we = fill_req && cache_on && !fill_inhibit;

    vcache_tag_valid #(.LINES(LINES)) u_valid (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_all  (flush_all),
        .flush_u    (usp_wr),
        .flush_s    (ssp_wr),
        .fill_we    (fill_we),
        .fill_idx   (fill_va[IDX_W-1:0]),
        .fill_super (fill_super),
        .rd_idx     (lk_va[IDX_W-1:0]),
        .rd_vu      (rd_vu),
        .rd_vs      (rd_vs)
    );

    vcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk  (clk),
        .we   (fill_we),
        .widx (fill_va[IDX_W-1:0]),
        .wtag (fill_va[LA_W-1:IDX_W]),
        .ridx (lk_va[IDX_W-1:0]),
        .rtag (rd_tag)
    );

    assign lk_hit = cache_on && (lk_super ? rd_vs : rd_vu) &&
                    (rd_tag == lk_va[LA_W-1:IDX_W]);

endmodule

// File: rtl/vcache_tag_chk.sv
module vcache_tag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr,
    input logic [15:0] csr_rdata,
    input logic        fault_ptab,
    input logic        fault_page,
    input logic        fault_prot,
    input logic        usp_wr,
    input logic        ssp_wr,
    input logic        lk_super,
    input logic        lk_hit,
    input logic        cache_on
);

    // R1
    hit_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> cache_on);

    // R7
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> csr_rdata[2]);

    // R7
    toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csr_rdata[2]) |=> !lk_hit);

    // R5
    user_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usp_wr |=> !(lk_hit && !lk_super));

    // R6
    super_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_wr |=> !(lk_hit && lk_super));

    // R10
    ptab_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ptab |=> (csr_rdata[15] && csr_rdata[3]));

    // R10
    page_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_page |=> (csr_rdata[14] && csr_rdata[3]));

    // R10
    prot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_prot |=> (csr_rdata[13] && csr_rdata[3]));

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[14] && !csr_wr) |=> csr_rdata[14]);

endmodule

bind vcache_tag vcache_tag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .csr_rdata  (csr_rdata),
    .fault_ptab (fault_ptab),
    .fault_page (fault_page),
    .fault_prot (fault_prot),
    .usp_wr     (usp_wr),
    .ssp_wr     (ssp_wr),
    .lk_super   (lk_super),
    .lk_hit     (lk_hit),
    .cache_on   (cache_on)
);

// File: tb/vcache_tag_bench.sv
module vcache_tag_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        fault_ptab = 1'b0, fault_page = 1'b0, fault_prot = 1'b0;
    logic        usp_wr = 1'b0, ssp_wr = 1'b0;
    logic [27:0] lk_va = '0;
    logic        lk_super = 1'b0;
    logic        lk_hit;
    logic        fill_req = 1'b0;
    logic [27:0] fill_va = '0;
    logic        fill_super = 1'b0, fill_inhibit = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] VA_A = 32'h0001_2340;
    localparam logic [31:0] VA_B = 32'h0001_6340;   // same index as A
    localparam logic [31:0] VA_C = 32'h0000_1000;
    localparam logic [31:0] VA_D = 32'h0000_2000;
    localparam logic [31:0] VA_E = 32'h0000_3000;

    always #2 clk = ~clk;

    vcache_tag u_vcache_tag (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .fault_ptab(fault_ptab), .fault_page(fault_page),
        .fault_prot(fault_prot), .usp_wr(usp_wr), .ssp_wr(ssp_wr),
        .lk_va(lk_va), .lk_super(lk_super), .lk_hit(lk_hit),
        .fill_req(fill_req), .fill_va(fill_va), .fill_super(fill_super),
        .fill_inhibit(fill_inhibit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input bit sup, input bit exp, input string req);
        lk_va = va[31:4];
        lk_super = sup;
        #1;
        chk(lk_hit == exp, req, int'(lk_hit), int'(exp));
    endtask

    task automatic fill(input logic [31:0] va, input bit sup, input bit inh);
        @(negedge clk);
        fill_req = 1'b1; fill_va = va[31:4]; fill_super = sup; fill_inhibit = inh;
        @(negedge clk);
        fill_req = 1'b0; fill_inhibit = 1'b0;
    endtask

    task automatic csr_write(input logic [15:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(csr_rdata == 16'h0, "R1", csr_rdata, 0);
        look(VA_A, 1'b0, 1'b0, "R1");
        look(VA_A, 1'b1, 1'b0, "R1");
    endtask

    task automatic t_basic();
        csr_write(16'h0004);
        @(negedge clk);
        fill(VA_A, 1'b0, 1'b0);
        look(VA_A, 1'b0, 1'b1, "R2");
        look(VA_A, 1'b1, 1'b0, "R4");
        look(VA_A ^ 32'h8000_0000, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_conflict();
        fill(VA_B, 1'b0, 1'b0);
        look(VA_B, 1'b0, 1'b1, "R3");
        look(VA_A, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_mode_swap();
        fill(VA_B, 1'b1, 1'b0);
        look(VA_B, 1'b1, 1'b1, "R4");
        look(VA_B, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_user_flush();
        fill(VA_C, 1'b0, 1'b0);
        fill(VA_D, 1'b1, 1'b0);
        @(negedge clk); usp_wr = 1'b1;
        @(negedge clk); usp_wr = 1'b0;
        look(VA_C, 1'b0, 1'b0, "R5");
        look(VA_D, 1'b1, 1'b1, "R5");
    endtask

    task automatic t_super_flush();
        fill(VA_C, 1'b0, 1'b0);
        @(negedge clk); ssp_wr = 1'b1;
        @(negedge clk); ssp_wr = 1'b0;
        look(VA_D, 1'b1, 1'b0, "R6");
        look(VA_C, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_inhibit();
        fill(VA_C + 32'h4000, 1'b0, 1'b1);
        look(VA_C, 1'b0, 1'b1, "R8");
        look(VA_C + 32'h4000, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_toggle();
        csr_write(16'h0004);
        @(negedge clk);
        look(VA_C, 1'b0, 1'b1, "R7");
        csr_write(16'h0000);
        look(VA_C, 1'b0, 1'b0, "R7");
        @(negedge clk);
        fill(VA_E, 1'b0, 1'b0);
        look(VA_E, 1'b0, 1'b0, "R7");
        csr_write(16'h0004);
        @(negedge clk);
        look(VA_C, 1'b0, 1'b0, "R7");
        look(VA_E, 1'b0, 1'b0, "R7");
        fill(VA_E, 1'b0, 1'b0);
        look(VA_E, 1'b0, 1'b1, "R2");
        csr_write(16'h0000);
        @(negedge clk);
        csr_write(16'h0004);
        @(negedge clk);
        look(VA_E, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_req = 1'b1; fill_va = VA_E[31:4]; fill_super = 1'b0; usp_wr = 1'b1;
        @(negedge clk);
        fill_req = 1'b0; usp_wr = 1'b0;
        look(VA_E, 1'b0, 1'b0, "R9");
        @(negedge clk);
        fill_req = 1'b1; fill_va = VA_D[31:4]; fill_super = 1'b1; ssp_wr = 1'b1;
        @(negedge clk);
        fill_req = 1'b0; ssp_wr = 1'b0;
        look(VA_D, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_csr();
        @(negedge clk); fault_page = 1'b1;
        @(negedge clk); fault_page = 1'b0;
        chk(csr_rdata == 16'h400C, "R10", csr_rdata, 16'h400C);
        repeat (3) @(negedge clk);
        chk(csr_rdata == 16'h400C, "R10", csr_rdata, 16'h400C);
        csr_write(16'hFFFF);
        chk(csr_rdata == 16'hE06F, "R10", csr_rdata, 16'hE06F);
        csr_write(16'h0004);
        chk(csr_rdata == 16'h0004, "R10", csr_rdata, 16'h0004);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = 16'h0004; fault_prot = 1'b1; fault_ptab = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; fault_prot = 1'b0; fault_ptab = 1'b0;
        chk(csr_rdata == 16'hA00C, "R10", csr_rdata, 16'hA00C);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_conflict();
        t_mode_swap();
        t_user_flush();
        t_super_flush();
        t_inhibit();
        t_toggle();
        t_same_cycle();
        t_csr();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule